// File: doc/BRIEF.md
# Loop Iteration Counter with Fused Zero Test

This block holds the iteration count for loops run by a microcoded datapath. The count register can be written in either of two ways: with a full-width operand from the datapath bus, or with a short constant taken straight from a function field of the microinstruction. Its registered contents are always presented on a read port so that microcode can move the count back onto the bus.

The loop condition is a single fused operation. When microcode issues a test, the block reports whether the count is zero. If the count is not zero, the same test takes one off the count at the clock edge. A loop body therefore needs only one condition per pass: load the trip count, then branch back on "not zero" until the test reports zero. A count of zero is reported at once, with no decrement first, and a count that has reached zero stays there under further tests.

Top module: `iter_counter`

## Requirements
- R1: A synchronous active-high reset clears the count to zero; the read port shows zero in the cycle after the reset edge.
- R2: A bus load writes the full 16-bit operand; the read port returns exactly that value from the next cycle (checked with 0x0000, 0xFFFF, 0x5555 and 0xAAAA).
- R3: A constant load writes the 4-bit field zero-extended into bit positions 3..0, upper bits cleared (checked with 1, 2, 4, 8 and 15); when bus load and constant load are strobed together, the bus operand is written.
- R4: A test while the count is non-zero drives the zero flag low in that cycle and leaves the count one lower in the next cycle.
- R5: A test while the count is zero drives the zero flag high in that cycle and leaves the count at zero; a zero load followed directly by a test reports zero on that first test.
- R6: When a load and a test are strobed in the same cycle, the load sets the new count and the zero flag reports on the count held before the load.
- R7: With no strobe active the count keeps its value.
- R8: After a bus load of 0xFFFF, exactly 65535 consecutive tests report non-zero before a test reports zero.
- R9: The zero flag is low in every cycle without a test strobe, whatever the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_ld | input | 1 | Load count from bus operand |
| bus_data | input | 16 | Bus operand |
| imm_ld | input | 1 | Load count from function-field constant |
| imm_val | input | 4 | Function-field constant |
| test_en | input | 1 | Fused zero test / decrement strobe |
| zero_hit | output | 1 | High when a test finds the count at zero |
| cnt_out | output | 16 | Registered count for readback |

## Verification
The assertions take the strobes to be well-defined levels sampled at the rising edge, with reset only ever applied for whole cycles; any mix of bus load, constant load and test in one cycle is treated as legal, with the bus load taking priority over the constant. The stimulus changes every input only on the falling edge, holds reset for full cycles, and deliberately combines loads with tests and both loads with each other so that the priority paths are reached. The full 65535-pass countdown is driven cycle by cycle, so the decrement path crosses every count value from 0xFFFF down to zero.

// File: rtl/iter_counter_pkg.sv
`timescale 1ns/1ps
package iter_counter_pkg;

    // Source selected for the next count value
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_IMM  = 2'd2,
        SRC_STEP = 2'd3
    } cnt_src_e;

endpackage

// File: rtl/iter_load_sel.sv
`timescale 1ns/1ps
module iter_load_sel
    import iter_counter_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int IMM_W  = 4
) (
    input  logic             bus_ld,
    input  logic [WIDTH-1:0] bus_data,
    input  logic             imm_ld,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             test_en,
    input  logic             step_ok,
    output cnt_src_e         src,
    output logic [WIDTH-1:0] ld_val
);

    localparam int PAD_W = WIDTH - IMM_W;

    // Bus load has priority over the constant load; a load beats the step.
    always_comb begin
        if (bus_ld) begin
            src    = SRC_BUS;
            ld_val = bus_data;
        end else if (imm_ld) begin
            src    = SRC_IMM;
            ld_val = {{PAD_W{1'b0}}, imm_val};
        end else if (test_en && step_ok) begin
            src    = SRC_STEP;
            ld_val = '0;
        end else begin
            src    = SRC_HOLD;
            ld_val = '0;
        end
    end

endmodule

// File: rtl/iter_zero_step.sv
`timescale 1ns/1ps
module iter_zero_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             test_en,
    output logic             is_zero,
    output logic             hit,
    output logic [WIDTH-1:0] dec_val
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        is_zero = (cnt == '0);
        hit     = test_en & is_zero;
        dec_val = cnt - ONE;
    end

endmodule

// File: rtl/iter_counter.sv
`timescale 1ns/1ps
module iter_counter
    import iter_counter_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int IMM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_ld,
    input  logic [WIDTH-1:0] bus_data,
    input  logic             imm_ld,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             test_en,
    output logic             zero_hit,
    output logic [WIDTH-1:0] cnt_out
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    logic             is_zero;
    logic [WIDTH-1:0] dec_val;
    logic [WIDTH-1:0] ld_val;
    cnt_src_e         src;

    iter_zero_step #(.WIDTH(WIDTH)) u_step (
        .cnt     (state_q.cnt),
        .test_en (test_en),
        .is_zero (is_zero),
        .hit     (zero_hit),
        .dec_val (dec_val)
    );

    iter_load_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
        .bus_ld   (bus_ld),
        .bus_data (bus_data),
        .imm_ld   (imm_ld),
        .imm_val  (imm_val),
        .test_en  (test_en),
        .step_ok  (!is_zero),
        .src      (src),
        .ld_val   (ld_val)
    );

    always_comb begin
        state_d = state_q;
        unique case (src)
            SRC_BUS,
            SRC_IMM:  state_d.cnt = ld_val;
            SRC_STEP: state_d.cnt = dec_val;
            default:  state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign cnt_out = state_q.cnt;

    // R1: reset clears the count
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> cnt_out == '0);

    // R2: bus operand written as given
    p_bus_load_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ld |=> cnt_out == $past(bus_data));

    // R3: constant zero-extended when the bus is not loading
    p_imm_load_r3: assert property (@(posedge clk) disable iff (rst)
        (imm_ld && !bus_ld) |=> cnt_out == {{(WIDTH-IMM_W){1'b0}}, $past(imm_val)});

    // R4: non-zero test decrements by one
    p_dec_one_r4: assert property (@(posedge clk) disable iff (rst)
        (test_en && !bus_ld && !imm_ld && cnt_out != '0) |=> cnt_out == $past(cnt_out) - WIDTH'(1));

    // R4: non-zero test reports not zero
    p_nz_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_out != '0) |-> !zero_hit);

    // R5: zero count under test stays zero and is reported
    p_zero_stick_r5: assert property (@(posedge clk) disable iff (rst)
        (test_en && !bus_ld && !imm_ld && cnt_out == '0) |=> cnt_out == '0);

    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (test_en && cnt_out == '0) |-> zero_hit);

    // R7: no strobe, no change
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !bus_ld && !imm_ld) |=> $stable(cnt_out));

    // R9: flag quiet without a test
    p_flag_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> !zero_hit);

endmodule

// File: tb/sim_iter_counter.sv
`timescale 1ns/1ps
module sim_iter_counter;

    localparam int W  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_ld = 1'b0;
    logic [W-1:0]  bus_data = '0;
    logic          imm_ld = 1'b0;
    logic [IW-1:0] imm_val = '0;
    logic          test_en = 1'b0;
    logic          zero_hit;
    logic [W-1:0]  cnt_out;

    always #2 clk = ~clk;   // 250 MHz

    iter_counter #(.WIDTH(W), .IMM_W(IW)) u0 (
        .clk      (clk),
        .rst      (rst),
        .bus_ld   (bus_ld),
        .bus_data (bus_data),
        .imm_ld   (imm_ld),
        .imm_val  (imm_val),
        .test_en  (test_en),
        .zero_hit (zero_hit),
        .cnt_out  (cnt_out)
    );

    typedef struct {
        logic [W-1:0] exp_cnt;
        logic         exp_z;
        string        req;
    } sb_item_t;

    sb_item_t     sb_q[$];
    int           n_checks = 0;
    int           n_errors = 0;
    logic [W-1:0] m_cnt = '0;     // bench model of the count
    logic         last_z;
    bit           done = 0;

    task automatic check_val(input string req, input string what,
                             input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed to scoreboard
    task automatic step(input logic bl, input logic [W-1:0] bd,
                        input logic il, input logic [IW-1:0] iv,
                        input logic te, input string req);
        sb_item_t it;
        @(negedge clk);
        bus_ld = bl; bus_data = bd; imm_ld = il; imm_val = iv; test_en = te;
        it.exp_z = te && (m_cnt == '0);
        if (bl)                         m_cnt = bd;
        else if (il)                    m_cnt = {{(W-IW){1'b0}}, iv};
        else if (te && m_cnt != '0)     m_cnt = m_cnt - 1'b1;
        it.exp_cnt = m_cnt;
        it.req     = req;
        sb_q.push_back(it);
        #1 last_z = zero_hit;
    endtask

    task automatic idle(input string req);
        step(1'b0, '0, 1'b0, '0, 1'b0, req);
    endtask

    // Monitor: flag just after the falling edge, count just after the rising edge
    initial begin
        logic     zf;
        sb_item_t it;
        forever begin
            @(negedge clk);
            #1 zf = zero_hit;
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check_val(it.req, "zero flag", W'(zf), W'(it.exp_z));
                check_val(it.req, "count", cnt_out, it.exp_cnt);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n_nz;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_val("R1", "count after reset", cnt_out, '0);

        // R2: bus load patterns, each followed by an idle hold (R7)
        step(1, 16'h0000, 0, 0, 0, "R2"); idle("R7");
        step(1, 16'hFFFF, 0, 0, 0, "R2"); idle("R7");
        step(1, 16'h5555, 0, 0, 0, "R2"); idle("R7");
        step(1, 16'hAAAA, 0, 0, 0, "R2"); idle("R7");

        // R3: constant loads, upper bits cleared
        step(0, 0, 1, 4'd1,  0, "R3");
        step(0, 0, 1, 4'd2,  0, "R3");
        step(0, 0, 1, 4'd4,  0, "R3");
        step(0, 0, 1, 4'd8,  0, "R3");
        step(0, 0, 1, 4'd15, 0, "R3");
        // R3: both loads together, bus wins
        step(1, 16'h1234, 1, 4'd7, 0, "R3");

        // R4: countdown from 3, then R5 at zero
        step(1, 16'd3, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, "R5");

        // R5: zero load then immediate test
        step(1, 16'h0000, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, "R5");

        // R9: no test while count is zero or non-zero
        idle("R9");
        step(0, 0, 1, 4'd9, 0, "R9");
        idle("R9");

        // R6: load with test in the same cycle
        step(1, 16'h0000, 0, 0, 0, "R6");
        step(1, 16'h0005, 0, 0, 1, "R6");   // flag from 0, count becomes 5
        step(0, 0, 1, 4'd2, 1, "R6");       // flag from 5, count becomes 2
        step(1, 16'h0001, 0, 0, 1, "R6");   // flag from 2, count becomes 1

        // R8: full countdown from all ones
        step(1, 16'hFFFF, 0, 0, 0, "R8");
        n_nz = 0;
        for (int i = 0; i < 70000; i++) begin
            step(0, 0, 0, 0, 1, "R8");
            if (last_z) break;
            n_nz++;
        end
        check_val("R8", "non-zero tests", W'(n_nz), W'(65535));
        idle("R7");

        // R1: reset in mid-run
        step(1, 16'hBEEF, 0, 0, 0, "R2");
        @(negedge clk);
        bus_ld = 0; imm_ld = 0; test_en = 0;
        #2;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_cnt = '0;
        #1;
        check_val("R1", "count after mid-run reset", cnt_out, '0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule